// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit evaluates the single-operand rotate, shift and bit-manipulation operations of an 8-bit accumulator-style processor core. Each cycle it takes an operand byte, the current flag byte, a 4-bit operation code and a 3-bit bit index. One clock edge later it presents the new result byte, the new flag byte and two write enables. The enables tell the register file and the flag register whether to take the values.

The operations are:
- eight rotates and shifts: circular, through carry, arithmetic, logical, and the undocumented left shift that fills bit 0 with a one;
- a bit test, which changes only flags;
- bit set and bit reset, which change only the result.

Memory read-modify-write sequencing and instruction decoding belong to the surrounding core.

Top module: `rsb_unit`

## Requirements
- R1: Code 0 (circular left) gives result {a[6:0],a[7]} with carry a[7]. Code 1 (circular right) gives {a[0],a[7:1]} with carry a[0].
- R2: Code 2 (left through carry) gives {a[6:0],C} with carry a[7]. Code 3 (right through carry) gives {C,a[7:1]} with carry a[0]. C is the incoming flag bit 0.
- R3: Code 5 (arithmetic right) gives {a[7],a[7:1]}. Code 7 (logical right) gives {0,a[7:1]}. Both set carry to a[0].
- R4: Code 4 (left arithmetic) gives {a[6:0],0}. Code 6 (left, one-fill) gives {a[6:0],1}. Both set carry to a[7].
- R5: For codes 0 to 7 the flag byte is built from the result y and the carry out, bit by bit:
  - bit 7 (sign) = y[7]
  - bit 6 (zero) = 1 when y is 0
  - bit 5 = y[5], bit 3 = y[3]
  - bit 2 (parity) = 1 when y has an even number of ones
  - bit 4 (half-carry) = 0, bit 1 (subtract) = 0
  - bit 0 = the carry out
- R6: Code 8 (bit test of a[idx]) keeps flag bit 0, sets bit 4, clears bit 1 and copies a[5] and a[3] to bits 5 and 3. It sets bits 6 and 2 exactly when a[idx] is 0.
- R7: For code 8, flag bit 7 is 1 only when idx is 7 and a[7] is 1. In every other case it is 0.
- R8: Code 9 clears bit idx and code 10 sets bit idx. All other bits of the result equal the operand, and the flag output equals the incoming flags.
- R9: The write enables depend on the code:
  - codes 0 to 7 raise both enables;
  - code 8 raises only the flag enable and passes the operand through as the result;
  - codes 9 and 10 raise only the result enable;
  - codes 11 to 15 raise neither, pass the operand through as the result and the incoming flags through as the flag output.
- R10: All outputs are registered with one cycle of latency. A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte |
| bit_idx_i | input | 3 | Bit index for codes 8 to 10 |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |
| res_we_o | output | 1 | Result write enable |
| flg_we_o | output | 1 | Flag write enable |

## Verification
The hardest case to reach is the sign flag of the bit test. It can only rise when index 7 meets an operand with bit 7 set, and uniform random stimulus rarely pairs the two. Directed cases therefore cover bit test at index 7 with bit 7 both set and clear, and at lower indices with bit 7 set. Directed cases also cover the zero results of the shifts (0x80 shifted left, 0x01 shifted right) and both carry-in values for the through-carry rotates. Random operations over all sixteen codes then cover the unused codes and the remaining flag bits.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_RLC = 4'd0, OP_RRC = 4'd1, OP_RL  = 4'd2, OP_RR  = 4'd3,
    OP_SLA = 4'd4, OP_SRA = 4'd5, OP_SLL = 4'd6, OP_SRL = 4'd7,
    OP_BIT = 4'd8, OP_RES = 4'd9, OP_SET = 4'd10
  } rsb_op_e;

  localparam int FC = 0;
  localparam int FN = 1;
  localparam int FP = 2;
  localparam int F3 = 3;
  localparam int FH = 4;
  localparam int F5 = 5;
  localparam int FZ = 6;
  localparam int FS = 7;
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift #(
  parameter int DW = 8
) (
  input  logic [2:0]    kind_i,
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  output logic [DW-1:0] y_o,
  output logic          cout_o
);
  always_comb begin
    y_o    = a_i;
    cout_o = 1'b0;
    case (kind_i)
      3'd0: begin y_o = {a_i[DW-2:0], a_i[DW-1]}; cout_o = a_i[DW-1]; end
      3'd1: begin y_o = {a_i[0], a_i[DW-1:1]};    cout_o = a_i[0];    end
      3'd2: begin y_o = {a_i[DW-2:0], cin_i};     cout_o = a_i[DW-1]; end
      3'd3: begin y_o = {cin_i, a_i[DW-1:1]};     cout_o = a_i[0];    end
      3'd4: begin y_o = {a_i[DW-2:0], 1'b0};      cout_o = a_i[DW-1]; end
      3'd5: begin y_o = {a_i[DW-1], a_i[DW-1:1]}; cout_o = a_i[0];    end
      3'd6: begin y_o = {a_i[DW-2:0], 1'b1};      cout_o = a_i[DW-1]; end
      default: begin y_o = {1'b0, a_i[DW-1:1]};   cout_o = a_i[0];    end
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic [DW-1:0] a_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    flags_i,
  output logic [DW-1:0] set_o,
  output logic [DW-1:0] clr_o,
  output logic [7:0]    test_flags_o
);
  logic [DW-1:0] mask;
  logic          hit;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (idx_i == IW'(i));
  end

  assign set_o = a_i | mask;
  assign clr_o = a_i & ~mask;
  assign hit   = |(a_i & mask);

  always_comb begin
    test_flags_o     = '0;
    test_flags_o[FC] = flags_i[FC];
    test_flags_o[FN] = 1'b0;
    test_flags_o[FH] = 1'b1;
    test_flags_o[F3] = a_i[3];
    test_flags_o[F5] = a_i[5];
    test_flags_o[FZ] = ~hit;
    test_flags_o[FP] = ~hit;
    test_flags_o[FS] = hit & mask[DW-1];
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  operand_i,
  input  logic [7:0]     flags_i,
  input  logic [IW-1:0]  bit_idx_i,
  output logic [DW-1:0]  result_o,
  output logic [7:0]     flags_o,
  output logic           res_we_o,
  output logic           flg_we_o
);
  logic [DW-1:0] sh_y, set_y, clr_y, nx_res;
  logic          sh_c, nx_rwe, nx_fwe;
  logic [7:0]    sh_flags, bt_flags, nx_flg;

  rsb_shift #(.DW(DW)) u_shift (
    .kind_i(op_i[2:0]), .a_i(operand_i), .cin_i(flags_i[FC]),
    .y_o(sh_y), .cout_o(sh_c)
  );

  rsb_bitop #(.DW(DW), .IW(IW)) u_bitop (
    .a_i(operand_i), .idx_i(bit_idx_i), .flags_i(flags_i),
    .set_o(set_y), .clr_o(clr_y), .test_flags_o(bt_flags)
  );

  always_comb begin
    sh_flags     = '0;
    sh_flags[FS] = sh_y[DW-1];
    sh_flags[FZ] = (sh_y == '0);
    sh_flags[F5] = sh_y[5];
    sh_flags[F3] = sh_y[3];
    sh_flags[FP] = ~^sh_y;
    sh_flags[FC] = sh_c;
  end

  always_comb begin
    nx_res = operand_i;
    nx_flg = flags_i;
    nx_rwe = 1'b0;
    nx_fwe = 1'b0;
    if (!op_i[3]) begin
      nx_res = sh_y; nx_flg = sh_flags; nx_rwe = 1'b1; nx_fwe = 1'b1;
    end else begin
      case (rsb_op_e'(op_i))
        OP_BIT: begin nx_flg = bt_flags; nx_fwe = 1'b1; end
        OP_RES: begin nx_res = clr_y; nx_rwe = 1'b1; end
        OP_SET: begin nx_res = set_y; nx_rwe = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
      res_we_o <= 1'b0;
      flg_we_o <= 1'b0;
    end else begin
      result_o <= nx_res;
      flags_o  <= nx_flg;
      res_we_o <= nx_rwe;
      flg_we_o <= nx_fwe;
    end
  end

  // R1: circular left puts old bit 7 in both bit 0 and carry
  a_r1_rlc_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_RLC) |->
      (result_o[0] == $past(operand_i[DW-1]) && flags_o[FC] == $past(operand_i[DW-1])));

  // R2: right through carry puts old carry in bit 7
  a_r2_rr_cin: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_RR) |->
      (result_o[DW-1] == $past(flags_i[FC]) && flags_o[FC] == $past(operand_i[0])));

  // R5: shifts clear half-carry and subtract and write both targets
  a_r5_shift_hn_clear: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_i[3])) |->
      (!flags_o[FH] && !flags_o[FN] && res_we_o && flg_we_o));

  // R6: bit test keeps carry, sets half-carry, writes only flags
  a_r6_bit_test: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_BIT) |->
      (flags_o[FC] == $past(flags_i[FC]) && flags_o[FH] && !res_we_o && flg_we_o
       && flags_o[FZ] == !$past(operand_i[bit_idx_i])));

  // R7: sign only for index 7
  a_r7_bit_sign: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_BIT && $past(bit_idx_i) != IW'(DW-1)) |->
      !flags_o[FS]);

  // R8: set and reset leave the flags alone
  a_r8_bitmod_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SET || $past(op_i) == OP_RES)) |->
      (flags_o == $past(flags_i) && res_we_o && !flg_we_o
       && $countones(result_o ^ $past(operand_i)) <= 1));
endmodule

// File: tb/rsb_unit_test.sv
module rsb_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] a = '0, f = '0;
  logic [2:0] idx = '0;
  logic [7:0] res, flg;
  logic       rwe, fwe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rsb_unit uut (
    .clk(clk), .rst(rst), .op_i(op), .operand_i(a), .flags_i(f),
    .bit_idx_i(idx), .result_o(res), .flags_o(flg),
    .res_we_o(rwe), .flg_we_o(fwe)
  );

  function automatic logic even8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return (n % 2) == 0;
  endfunction

  // returns {result, flags, rwe, fwe}
  function automatic logic [17:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] fl, input logic [2:0] k);
    logic [7:0] y = x, nf = fl;
    logic c = 1'b0, w_r = 1'b0, w_f = 1'b0, tb;
    if (o < 8) begin
      case (o)
        0: begin y = (x << 1) | (x >> 7); c = x[7]; end
        1: begin y = (x >> 1) | (x << 7); c = x[0]; end
        2: begin y = (x << 1) | {7'd0, fl[0]}; c = x[7]; end
        3: begin y = (x >> 1) | {fl[0], 7'd0}; c = x[0]; end
        4: begin y = x << 1; c = x[7]; end
        5: begin y = (x >> 1) | (x & 8'h80); c = x[0]; end
        6: begin y = (x << 1) | 8'h01; c = x[7]; end
        default: begin y = x >> 1; c = x[0]; end
      endcase
      nf = {y[7], y == 8'h00, y[5], 1'b0, y[3], even8(y), 1'b0, c};
      w_r = 1; w_f = 1;
    end else if (o == 8) begin
      tb = x[k];
      nf = {tb && k == 3'd7, !tb, x[5], 1'b1, x[3], !tb, 1'b0, fl[0]};
      w_f = 1;
    end else if (o == 9) begin
      y = x & ~(8'h01 << k); w_r = 1;
    end else if (o == 10) begin
      y = x | (8'h01 << k); w_r = 1;
    end
    return {y, nf, w_r, w_f};
  endfunction

  function automatic string rtag(input logic [3:0] o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      5, 7: return "R3";
      4, 6: return "R4";
      8: return "R9";
      9, 10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%02h f=%02h idx=%0d: actual %0h expected %0h",
               tag, what, op, a, f, idx, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] x, input logic [7:0] fl,
                     input logic [2:0] k);
    logic [17:0] e;
    @(negedge clk);
    op = o; a = x; f = fl; idx = k;
    e = model(o, x, fl, k);
    @(negedge clk);
    chk(rtag(o), "result", 32'(res), 32'(e[17:10]));
    if (o < 8) chk("R5", "flags", 32'(flg), 32'(e[9:2]));
    else if (o == 8) begin
      chk("R6", "flags", 32'(flg), 32'(e[9:2]));
      if (k == 3'd7 || x[7]) chk("R7", "sign", 32'(flg[7]), 32'(e[9]));
    end else if (o == 9 || o == 10) chk("R8", "flags", 32'(flg), 32'(e[9:2]));
    else chk("R9", "flags", 32'(flg), 32'(e[9:2]));
    chk("R9", "enables", 32'({rwe, fwe}), 32'(e[1:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", 32'({res, flg, rwe, fwe}), 32'd0);
    rst = 1'b0;
    // directed corners
    run(0, 8'h80, 8'h00, 0);
    run(1, 8'h01, 8'h00, 0);
    run(2, 8'h80, 8'h00, 0);
    run(2, 8'h80, 8'h01, 0);
    run(3, 8'h01, 8'h00, 0);
    run(3, 8'h01, 8'h01, 0);
    run(4, 8'h80, 8'hFF, 0);
    run(6, 8'h80, 8'h00, 0);
    run(5, 8'h81, 8'h00, 0);
    run(7, 8'h01, 8'hFF, 0);
    run(7, 8'hFF, 8'h00, 0);
    run(8, 8'h80, 8'h01, 7);
    run(8, 8'h7F, 8'h00, 7);
    run(8, 8'hFF, 8'h00, 3);
    run(8, 8'h00, 8'hFF, 5);
    run(9, 8'hFF, 8'h5A, 4);
    run(10, 8'h00, 8'hA5, 7);
    run(12, 8'h3C, 8'hC3, 2);
    run(15, 8'hAA, 8'h55, 1);
    // check latency and reset once more
    @(negedge clk); rst = 1'b1;
    @(negedge clk); chk("R10", "reset outputs", 32'({res, flg, rwe, fwe}), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 3000; i++)
      run(4'($urandom % 16), 8'($urandom), 8'($urandom), 3'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule